// File: doc/BRIEF.md
# Credit-Based Flit Link

This block carries fixed-width flits from a producer to a consumer across a link whose forward path and credit return path each have a configurable register delay. The sending side keeps a credit counter. It accepts a flit from the producer only while it holds at least one credit, and it spends one credit on each flit it accepts. The receiving side stores arriving flits in a buffer of `DEPTH` slots and hands them to the consumer through a valid/ready handshake.

Freed slots become credits again. The receiver does not return them one at a time. It collects them and sends back a single message holding a count, either when `BUNDLE` credits have built up or when the oldest collected credit has waited `TIMEOUT` cycles. After reset the sender holds no credits. It can send only once the receiver's opening grant of `DEPTH` credits has travelled back through the return path.

Top module: `credit_link`

## Requirements
- R1: While reset is held, and for the first CRD_LAT+1 rising edges after reset is released, `in_ready` is 0. It becomes 1 after rising edge CRD_LAT+2.
- R2: With no slot freed by the consumer, the link accepts no more than DEPTH flits in total. `in_ready` is 0 whenever the sender holds no credits.
- R3: Each accepted flit reaches `out_data` exactly once, in order of acceptance, for any setting of FWD_LAT and CRD_LAT. The receive buffer is never written while it is full.
- R4: Suppose the sender is out of credits and the consumer pops BUNDLE flits on consecutive edges. Counting from the BUNDLE-th pop, `in_ready` stays 0 for CRD_LAT edges and is 1 after edge CRD_LAT+1.
- R5: Suppose the sender is out of credits and the consumer pops a single flit, which leaves fewer than BUNDLE credits pending. Counting from that pop, `in_ready` stays 0 for TIMEOUT+CRD_LAT edges and is 1 after edge TIMEOUT+CRD_LAT+1.
- R6: When a credit return and a flit acceptance happen on the same edge, neither is lost. The sender's credit count never exceeds DEPTH, and once the link is idle and drained it accepts exactly DEPTH flits against a stalled consumer.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R8: Suppose a flit is accepted while the receive buffer is empty. Counting from the accepting edge, `out_valid` stays 0 for FWD_LAT-1 edges and becomes 1 after edge FWD_LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers a flit |
| in_ready | output | 1 | Sender holds a credit and takes the flit |
| in_data | input | DATA_W | Flit from the producer |
| out_valid | output | 1 | Receive buffer holds a flit |
| out_ready | input | 1 | Consumer takes the head flit |
| out_data | output | DATA_W | Head flit of the receive buffer |

## Verification
The bench builds the link with DEPTH 4, BUNDLE 3, TIMEOUT 6, FWD_LAT 2 and CRD_LAT 3. With a four-slot buffer, the credit stall and a completely full buffer are reached within a handful of flits. Because the two delays differ and BUNDLE does not divide DEPTH, both the threshold return and the timeout return can be timed exactly. With a round trip longer than the buffer, the streaming phase under an irregular consumer stalls again and again, which exercises same-edge credit return and flit acceptance.

// File: rtl/credit_pkg.sv
// Shared definitions for the credit-based flit link.
package credit_pkg;

    // Receiver phase: opening grant, then normal credit return.
    typedef enum logic {
        RX_GRANT = 1'b0,
        RX_RUN   = 1'b1
    } rx_phase_e;

    // Bits needed to hold values 0..max_val.
    function automatic int count_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/link_pipe.sv
// Fixed-delay register pipe for a valid/data pair. It has no backpressure,
// so the consumer at the far end must always be able to take what arrives.
// LAT = 0 gives a plain wire.
module link_pipe #(
    parameter int W   = 8,
    parameter int LAT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    generate
        if (LAT == 0) begin : g_wire
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_regs
            logic [LAT-1:0] vld;
            logic [W-1:0]   dat [LAT];

            // Shift the valid bits; these are the only stage state that is reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld <= '0;
                end else begin
                    vld[0] <= in_valid;
                    for (int i = 1; i < LAT; i++) vld[i] <= vld[i-1];
                end
            end

            // Shift the payload alongside its valid bit.
            always_ff @(posedge clk) begin
                dat[0] <= in_data;
                for (int i = 1; i < LAT; i++) dat[i] <= dat[i-1];
            end

            assign out_valid = vld[LAT-1];
            assign out_data  = dat[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/credit_tx.sv
// Sending side. It holds a credit count, accepts a producer flit only when
// the count is non-zero, and adds in returned credits. A return and a send on
// the same edge are both applied. It assumes the returned credits never
// push the count above DEPTH.
module credit_tx #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CW    = credit_pkg::count_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    input  logic              ret_valid,
    input  logic [CW-1:0]     ret_cnt,
    output logic [CW-1:0]     credits
);
    logic [CW-1:0] cnt;
    logic          send;

    assign in_ready  = (cnt != '0);
    assign send      = in_valid && in_ready;
    assign fwd_valid = send;
    assign fwd_data  = in_data;
    assign credits   = cnt;

    // Count update: add returned credits, subtract one for an accepted flit.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + (ret_valid ? ret_cnt : '0) - CW'(send);
    end
endmodule

// File: rtl/rx_fifo.sv
// Receive buffer: a circular FIFO of DEPTH slots that shows its head word.
// A write while full is dropped, and the credit scheme exists to make that
// case unreachable. A read while empty is ignored.
module rx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = credit_pkg::count_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] fill
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          wr_ok, rd_ok;

    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign rdata = mem[rptr];

    // Pointer and occupancy bookkeeping, with wrap for any DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (rd_ok) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            fill <= fill + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // Slot storage; not reset.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wdata;
    end
endmodule

// File: rtl/credit_rx.sv
// Receiving side. It buffers arriving flits, serves the consumer, and returns
// freed slots as counted credit messages. The first message after reset
// grants DEPTH credits. After that a message goes out when the pending count
// reaches BUNDLE, or when credits have been pending for TIMEOUT cycles. It
// assumes 1 <= BUNDLE <= DEPTH and TIMEOUT >= 1.
module credit_rx #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 8,
    parameter int BUNDLE  = 4,
    parameter int TIMEOUT = 8,
    localparam int CW     = credit_pkg::count_width(DEPTH),
    localparam int AGW    = credit_pkg::count_width(TIMEOUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwd_valid,
    input  logic [DATA_W-1:0] fwd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              ret_valid,
    output logic [CW-1:0]     ret_cnt,
    output logic              granting,
    output logic [CW-1:0]     fill,
    output logic              buf_full
);
    import credit_pkg::*;

    rx_phase_e      phase;
    logic           empty, pop, due;
    logic [CW-1:0]  pend, pend_sum;
    logic [AGW-1:0] age;

    rx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fwd_valid),
        .wdata (fwd_data),
        .rd    (pop),
        .rdata (out_data),
        .empty (empty),
        .full  (buf_full),
        .fill  (fill)
    );

    assign out_valid = !empty;
    assign pop       = out_valid && out_ready;
    assign granting  = (phase == RX_GRANT);

    // Decide whether pending credits go out on this edge.
    always_comb begin
        pend_sum = pend + CW'(pop);
        due      = (pend_sum >= CW'(BUNDLE)) ||
                   ((pend != '0) && (age == AGW'(TIMEOUT-1)));
    end

    // Credit message register, pending count and wait timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= RX_GRANT;
            ret_valid <= 1'b0;
            ret_cnt   <= '0;
            pend      <= '0;
            age       <= '0;
        end else if (phase == RX_GRANT) begin
            phase     <= RX_RUN;
            ret_valid <= 1'b1;
            ret_cnt   <= CW'(DEPTH);
            pend      <= pend_sum;
            age       <= '0;
        end else if (due) begin
            ret_valid <= 1'b1;
            ret_cnt   <= pend_sum;
            pend      <= '0;
            age       <= '0;
        end else begin
            ret_valid <= 1'b0;
            pend      <= pend_sum;
            age       <= (pend == '0) ? '0 : age + 1'b1;
        end
    end
endmodule

// File: rtl/credit_link.sv
// Top of the credit-based flit link. It wires the sender to a forward delay
// pipe, the pipe to the receiver, and the receiver's credit messages back
// through a return delay pipe. Both delays are parameters, and the buffer
// depth alone bounds what can be in flight.
module credit_link #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 8,
    parameter int BUNDLE  = 4,
    parameter int TIMEOUT = 8,
    parameter int FWD_LAT = 2,
    parameter int CRD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int CW = credit_pkg::count_width(DEPTH);

    logic              tx_valid, rx_in_valid, rx_ret_valid, tx_ret_valid;
    logic [DATA_W-1:0] tx_data, rx_in_data;
    logic [CW-1:0]     rx_ret_cnt, tx_ret_cnt, tx_credits, rx_fill;
    logic              rx_granting, rx_full;

    credit_tx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .fwd_valid (tx_valid),
        .fwd_data  (tx_data),
        .ret_valid (tx_ret_valid),
        .ret_cnt   (tx_ret_cnt),
        .credits   (tx_credits)
    );

    link_pipe #(.W(DATA_W), .LAT(FWD_LAT)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_data   (tx_data),
        .out_valid (rx_in_valid),
        .out_data  (rx_in_data)
    );

    credit_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BUNDLE(BUNDLE),
                .TIMEOUT(TIMEOUT)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_valid (rx_in_valid),
        .fwd_data  (rx_in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .ret_valid (rx_ret_valid),
        .ret_cnt   (rx_ret_cnt),
        .granting  (rx_granting),
        .fill      (rx_fill),
        .buf_full  (rx_full)
    );

    link_pipe #(.W(CW), .LAT(CRD_LAT)) u_crd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_ret_valid),
        .in_data   (rx_ret_cnt),
        .out_valid (tx_ret_valid),
        .out_data  (tx_ret_cnt)
    );
endmodule

// File: rtl/credit_link_chk.sv
// Property checker for credit_link, attached with bind. It observes the
// sender's credit count, the receive buffer and the credit messages.
module credit_link_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CW    = credit_pkg::count_width(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [CW-1:0]     credits,
    input logic [CW-1:0]     fill,
    input logic              buf_full,
    input logic              buf_wr,
    input logic              granting,
    input logic              ret_valid,
    input logic [CW-1:0]     ret_cnt
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_wr && buf_full));

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R6
    credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        credits <= CW'(DEPTH));

    // R1
    startup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        granting |-> (credits == '0));

    // R4
    bundle_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ((ret_cnt != '0) && (ret_cnt <= CW'(DEPTH))));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind credit_link credit_link_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .credits   (tx_credits),
    .fill      (rx_fill),
    .buf_full  (rx_full),
    .buf_wr    (rx_in_valid),
    .granting  (rx_granting),
    .ret_valid (rx_ret_valid),
    .ret_cnt   (rx_ret_cnt)
);

// File: tb/credit_link_test.sv
// Scoreboard bench for credit_link. Drivers push each accepted flit into a
// queue; a monitor pops the queue and compares as the consumer takes flits.
module credit_link_test;
    localparam int DW   = 16;
    localparam int DEP  = 4;
    localparam int BUN  = 3;
    localparam int TOUT = 6;
    localparam int FLAT = 2;
    localparam int CLAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int compared = 0;
    int mismatched = 0;
    logic [DW-1:0] exp_q[$];
    bit stream_done = 1'b0;

    always #5 clk = ~clk;

    credit_link #(.DATA_W(DW), .DEPTH(DEP), .BUNDLE(BUN), .TIMEOUT(TOUT),
                  .FWD_LAT(FLAT), .CRD_LAT(CLAT)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Offer a flit every cycle for a fixed number of cycles; return how many were taken.
    task automatic offer_for(input int cycles, input int base, output int taken);
        bit acc;
        taken = 0;
        for (int c = 0; c < cycles; c++) begin
            in_valid = 1'b1;
            in_data  = DW'(base + taken);
            acc = in_ready;
            @(posedge clk);
            if (acc) begin
                exp_q.push_back(in_data);
                taken++;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // Send n flits back to back, waiting out any credit stall.
    task automatic send_n(input int n, input int base);
        bit acc;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = DW'(base + i);
            do begin
                acc = in_ready;
                @(posedge clk);
                if (acc) exp_q.push_back(in_data);
                @(negedge clk);
            end while (!acc);
        end
        in_valid = 1'b0;
    endtask

    // Monitor: compare every flit the consumer takes against the scoreboard (R3).
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected flit", int'(out_data), -1);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R3 order", int'(out_data), int'(e));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Consumer with an irregular ready pattern for the streaming phase.
    task automatic lumpy_consumer();
        int c = 0;
        while (!stream_done) begin
            out_ready = (c % 3 != 2) && (c % 7 != 5);
            c++;
            tick();
        end
        out_ready = 1'b1;
    endtask

    initial begin
        int taken;
        logic [DW-1:0] held;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b0, "R1 in_ready in reset", int'(in_ready), 0);
        check(out_valid == 1'b0, "R3 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        // R1: opening grant timing
        for (int n = 1; n <= CLAT + 2; n++) begin
            tick();
            check(in_ready == (n == CLAT + 2), "R1 grant arrival",
                  int'(in_ready), int'(n == CLAT + 2));
        end

        // R8: forward latency of one flit into an empty buffer
        in_valid = 1'b1;
        in_data  = 16'h0A5A;
        check(in_ready == 1'b1, "R8 ready before send", int'(in_ready), 1);
        @(posedge clk);
        exp_q.push_back(in_data);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 1; k <= FLAT; k++) begin
            tick();
            check(out_valid == (k == FLAT), "R8 out_valid latency",
                  int'(out_valid), int'(k == FLAT));
        end

        // R7: head flit held while the consumer stalls
        held = out_data;
        repeat (4) tick();
        check(out_valid && out_data == held, "R7 hold", int'(out_data), int'(held));

        // R2: no more than DEPTH flits without returned credits
        offer_for(3 * DEP + FLAT + CLAT + 10, 16'h0100, taken);
        check(taken == DEP - 1, "R2 stall count", taken, DEP - 1);
        check(in_ready == 1'b0, "R2 in_ready at zero credits", int'(in_ready), 0);
        repeat (FLAT + 2) tick();

        // R4: bundle return after BUNDLE pops
        out_ready = 1'b1;
        repeat (BUN) @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        for (int n = 1; n <= CLAT + 1; n++) begin
            tick();
            check(in_ready == (n == CLAT + 1), "R4 bundle return",
                  int'(in_ready), int'(n == CLAT + 1));
        end

        // R6: exactly the bundled credits are usable
        offer_for(2 * DEP + 10, 16'h0200, taken);
        check(taken == BUN, "R6 bundle credits", taken, BUN);
        repeat (FLAT + 2) tick();

        // R5: timeout return of a lone credit
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        for (int n = 1; n <= TOUT + CLAT + 1; n++) begin
            tick();
            check(in_ready == (n == TOUT + CLAT + 1), "R5 timeout return",
                  int'(in_ready), int'(n == TOUT + CLAT + 1));
        end

        // R6/R3: streaming with simultaneous return and send
        fork
            begin
                send_n(40, 16'h1000);
                stream_done = 1'b1;
            end
            lumpy_consumer();
        join
        repeat (60) tick();
        check(exp_q.size() == 0, "R3 all delivered", exp_q.size(), 0);
        check(in_ready == 1'b1, "R6 credits restored", int'(in_ready), 1);

        // R6: after idle, exactly DEPTH credits remain
        out_ready = 1'b0;
        offer_for(3 * DEP + 10, 16'h2000, taken);
        check(taken == DEP, "R6 full credit set", taken, DEP);
        out_ready = 1'b1;
        repeat (40) tick();
        check(exp_q.size() == 0, "R3 final drain", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule